// File: doc/BRIEF.md
# Deadline-Aware Stream Output Queue

This block sits between a producer of outgoing frames and the lower transmit layer. It buffers transmit requests in arrival order and stamps each one with the value of a free-running cycle counter at the moment it is accepted. The oldest request is the only one offered downstream. While it is outstanding, a deadline is held equal to its stamp plus a configured delay bound. A success confirm from below retires the request. If the deadline arrives first, the block withdraws the request with a clear, waits for the lower layer to acknowledge the clear, and retires the request as failed.

Each retired request produces a one-cycle status pulse with a pass/fail flag. A request whose deadline has already passed when it reaches the front of the queue is never offered. It is retired at once as failed. Deadlines are compared by modular subtraction on the counter, so counter wrap does no harm while the delay bound stays below half the counter range.

Top module: `deadline_stream_queue`

## Requirements
- R1: After reset, `up_ready` is 1 and `lo_req`, `lo_clear` and `st_valid` are 0.
- R2: Requests are offered downstream in the order they were accepted. In every cycle `lo_req` is high, `lo_data` carries the payload of the oldest stored request.
- R3: `up_ready` is 0 while DEPTH requests are stored. A push presented while `up_ready` is 0 is not stored.
- R4: With an empty queue and an idle controller, `lo_req` is high for exactly one cycle. That cycle follows the clock edge after the edge that accepted the request. At most one request is outstanding at a time.
- R5: A `lo_cfm` sampled while a request is outstanding gives, in the next cycle, `st_valid`=1 with `st_ok`=1 and no `lo_clear`.
- R6: A request is stamped with the counter value `t` at its accepting edge. If unconfirmed, `lo_clear` first goes high after the edge at which the counter equals `t + delay_bound` (for `delay_bound` >= 3), which is `delay_bound` edges after acceptance.
- R7: `lo_clear` stays high until `lo_clr_ack` is sampled high. No `lo_req` is issued meanwhile. The cycle after the acknowledge shows `st_valid`=1 with `st_ok`=0.
- R8: A `lo_cfm` sampled at the same edge at which the deadline is reached counts as a success: `st_ok`=1 and no `lo_clear`.
- R9: A request whose deadline has passed when it becomes the oldest is never offered (`lo_req` stays 0 for it). It is retired with `st_valid`=1, `st_ok`=0.
- R10: The timeout in R6 keeps its exact timing when the counter wraps between a request's stamp and its deadline, provided `delay_bound` < 2^(TIME_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| delay_bound | input | TIME_W | Allowed cycles from acceptance to success |
| up_valid | input | 1 | Upper layer presents a request |
| up_data | input | DATA_W | Request payload |
| up_ready | output | 1 | Queue can accept a request this cycle |
| lo_req | output | 1 | One-cycle launch of the oldest request |
| lo_data | output | DATA_W | Payload of the oldest request |
| lo_cfm | input | 1 | Lower layer reports successful delivery |
| lo_clear | output | 1 | Withdraw the outstanding request |
| lo_clr_ack | input | 1 | Lower layer has completed the withdrawal |
| st_valid | output | 1 | One-cycle status pulse for a retired request |
| st_ok | output | 1 | Status flag: 1 delivered, 0 expired or dropped |

## Verification
Faults in the stored stamp or the held deadline show up as a `lo_clear` that arrives one or more edges early or late. The bench therefore measures the clear edge exactly, including across counter wrap. A wrong read pointer shows as a reordered or repeated payload at the next `lo_req`. A mishandled state transition shows within a cycle or two: a missing status pulse, a wrong pass/fail flag, or a launch for a request that should have been dropped as stale.

// File: rtl/dlq_pkg.sv
package dlq_pkg;

    // Controller phases for the head request
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,  // choose: launch head or drop it as stale
        PH_SEND   = 3'd1,  // lo_req driven this cycle
        PH_AWAIT  = 3'd2,  // outstanding, racing confirm against deadline
        PH_ABORT  = 3'd3,  // clear driven, waiting for acknowledge
        PH_RETIRE = 3'd4   // status pulse and pop
    } phase_t;

endpackage

// File: rtl/dlq_timebase.sv
module dlq_timebase #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] now_o
);
    logic [TIME_W-1:0] now_d, now_q;

    always_comb begin
        now_d = now_q + TIME_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_d;
    end

    assign now_o = now_q;

    p_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> now_q == $past(now_q) + TIME_W'(1));

endmodule

// File: rtl/dlq_entry_fifo.sv
module dlq_entry_fifo #(
    parameter int DATA_W = 16,
    parameter int TIME_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [TIME_W-1:0] stamp_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_data_o,
    output logic [TIME_W-1:0] head_stamp_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    logic [DATA_W-1:0] data_mem  [DEPTH];
    logic [TIME_W-1:0] stamp_mem [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        s_d = s_q;
        if (push_i) s_d.wr = bump(s_q.wr);
        if (pop_i)  s_d.rd = bump(s_q.rd);
        s_d.cnt = s_q.cnt + CNT_W'(push_i) - CNT_W'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push_i && s_q.wr == PTR_W'(i)) begin
                data_mem[i]  <= data_i;
                stamp_mem[i] <= stamp_i;
            end
        end
    end

    assign head_data_o  = data_mem[s_q.rd];
    assign head_stamp_o = stamp_mem[s_q.rd];
    assign empty_o      = (s_q.cnt == '0);
    assign full_o       = (s_q.cnt == CNT_W'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> s_q.cnt < CNT_W'(DEPTH));

    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> s_q.cnt != '0);

endmodule

// File: rtl/dlq_deadline.sv
module dlq_deadline #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now_i,
    input  logic [TIME_W-1:0] stamp_i,
    input  logic [TIME_W-1:0] bound_i,
    input  logic              arm_i,
    input  logic              disarm_i,
    output logic              head_late_o,
    output logic              expired_o
);
    typedef struct packed {
        logic              armed;
        logic [TIME_W-1:0] due;
    } tmr_st_t;

    tmr_st_t t_d, t_q;
    logic [TIME_W-1:0] head_due;

    // deadline reached when (now - due) is non-negative modulo 2^TIME_W
    function automatic logic reached(input logic [TIME_W-1:0] now,
                                     input logic [TIME_W-1:0] due);
        logic [TIME_W-1:0] gap;
        gap = now - due;
        return ~gap[TIME_W-1];
    endfunction

    always_comb begin
        head_due = stamp_i + bound_i;
        t_d = t_q;
        if (arm_i) begin
            t_d.armed = 1'b1;
            t_d.due   = head_due;
        end else if (disarm_i) begin
            t_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign head_late_o = reached(now_i, head_due);
    assign expired_o   = t_q.armed && reached(now_i, t_q.due);

    p_due_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.armed && !arm_i) |=> $stable(t_q.due));

    p_arm_when_fresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |-> !head_late_o);

endmodule

// File: rtl/dlq_ctrl.sv
module dlq_ctrl
    import dlq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic empty_i,
    input  logic head_late_i,
    input  logic expired_i,
    input  logic cfm_i,
    input  logic clr_ack_i,
    output logic pop_o,
    output logic arm_o,
    output logic disarm_o,
    output logic lo_req_o,
    output logic lo_clear_o,
    output logic st_valid_o,
    output logic st_ok_o
);
    typedef struct packed {
        phase_t ph;
        logic   ok;
    } ctl_st_t;

    ctl_st_t c_d, c_q;
    logic    live;

    always_comb begin
        c_d      = c_q;
        pop_o    = 1'b0;
        arm_o    = 1'b0;
        disarm_o = 1'b0;
        live     = (c_q.ph == PH_SEND) || (c_q.ph == PH_AWAIT);
        case (c_q.ph)
            PH_IDLE: begin
                if (!empty_i) begin
                    if (head_late_i) begin
                        c_d.ph = PH_RETIRE;
                        c_d.ok = 1'b0;
                    end else begin
                        c_d.ph = PH_SEND;
                        arm_o  = 1'b1;
                    end
                end
            end
            PH_SEND, PH_AWAIT: begin
                // a confirm wins a tie with the deadline
                if (cfm_i) begin
                    c_d.ph   = PH_RETIRE;
                    c_d.ok   = 1'b1;
                    disarm_o = 1'b1;
                end else if (expired_i) begin
                    c_d.ph   = PH_ABORT;
                    disarm_o = 1'b1;
                end else begin
                    c_d.ph = PH_AWAIT;
                end
            end
            PH_ABORT: begin
                if (clr_ack_i) begin
                    c_d.ph = PH_RETIRE;
                    c_d.ok = 1'b0;
                end
            end
            PH_RETIRE: begin
                pop_o  = 1'b1;
                c_d.ph = PH_IDLE;
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{ph: PH_IDLE, ok: 1'b0};
        else        c_q <= c_d;
    end

    assign lo_req_o   = (c_q.ph == PH_SEND);
    assign lo_clear_o = (c_q.ph == PH_ABORT);
    assign st_valid_o = (c_q.ph == PH_RETIRE);
    assign st_ok_o    = c_q.ok;

    p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_req_o |=> !lo_req_o);

    p_clear_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_clear_o && !clr_ack_i) |=> lo_clear_o);

    p_no_req_in_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lo_clear_o |-> !lo_req_o);

    p_fail_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_clear_o && clr_ack_i) |=> (st_valid_o && !st_ok_o));

    p_confirm_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cfm_i) |=> (st_valid_o && st_ok_o && !lo_clear_o));

    p_stale_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ph == PH_IDLE && !empty_i && head_late_i) |=>
            (st_valid_o && !st_ok_o && !lo_req_o));

endmodule

// File: rtl/deadline_stream_queue.sv
module deadline_stream_queue #(
    parameter int DATA_W = 16,
    parameter int TIME_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] delay_bound,
    input  logic              up_valid,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_ready,
    output logic              lo_req,
    output logic [DATA_W-1:0] lo_data,
    input  logic              lo_cfm,
    output logic              lo_clear,
    input  logic              lo_clr_ack,
    output logic              st_valid,
    output logic              st_ok
);
    logic [TIME_W-1:0] now;
    logic [TIME_W-1:0] head_stamp;
    logic              push, pop, empty, full;
    logic              arm, disarm, head_late, expired;

    assign up_ready = !full;
    assign push     = up_valid && !full;

    dlq_timebase #(.TIME_W(TIME_W)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .now_o (now)
    );

    dlq_entry_fifo #(.DATA_W(DATA_W), .TIME_W(TIME_W), .DEPTH(DEPTH)) u_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push),
        .data_i       (up_data),
        .stamp_i      (now),
        .pop_i        (pop),
        .head_data_o  (lo_data),
        .head_stamp_o (head_stamp),
        .empty_o      (empty),
        .full_o       (full)
    );

    dlq_deadline #(.TIME_W(TIME_W)) u_deadline (
        .clk         (clk),
        .rst_n       (rst_n),
        .now_i       (now),
        .stamp_i     (head_stamp),
        .bound_i     (delay_bound),
        .arm_i       (arm),
        .disarm_i    (disarm),
        .head_late_o (head_late),
        .expired_o   (expired)
    );

    dlq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .empty_i     (empty),
        .head_late_i (head_late),
        .expired_i   (expired),
        .cfm_i       (lo_cfm),
        .clr_ack_i   (lo_clr_ack),
        .pop_o       (pop),
        .arm_o       (arm),
        .disarm_o    (disarm),
        .lo_req_o    (lo_req),
        .lo_clear_o  (lo_clear),
        .st_valid_o  (st_valid),
        .st_ok_o     (st_ok)
    );

endmodule

// File: tb/deadline_stream_queue_bench.sv
module deadline_stream_queue_bench;
    localparam int DW = 16;
    localparam int TW = 8;
    localparam int DP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] delay_bound = '0;
    logic          up_valid = 1'b0;
    logic [DW-1:0] up_data = '0;
    logic          up_ready;
    logic          lo_req;
    logic [DW-1:0] lo_data;
    logic          lo_cfm = 1'b0;
    logic          lo_clear;
    logic          lo_clr_ack = 1'b0;
    logic          st_valid;
    logic          st_ok;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    int req_cnt  = 0;
    int pass_cnt = 0;
    int fail_cnt = 0;
    logic [DW-1:0] req_log [16];

    always #10 clk = ~clk;  // 50 MHz

    deadline_stream_queue #(.DATA_W(DW), .TIME_W(TW), .DEPTH(DP)) u_deadline_stream_queue (
        .clk(clk), .rst_n(rst_n), .delay_bound(delay_bound),
        .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
        .lo_req(lo_req), .lo_data(lo_data), .lo_cfm(lo_cfm),
        .lo_clear(lo_clear), .lo_clr_ack(lo_clr_ack),
        .st_valid(st_valid), .st_ok(st_ok)
    );

    // port monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (lo_req) begin
                req_log[req_cnt % 16] = lo_data;
                req_cnt++;
            end
            if (st_valid) begin
                if (st_ok) pass_cnt++;
                else       fail_cnt++;
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual cycles %0d expected < 100000", cycles);
            finish_run();
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push_one(input logic [DW-1:0] d);
        up_valid = 1'b1;
        up_data  = d;
        step();
        up_valid = 1'b0;
    endtask

    task automatic t_reset();
        check(up_ready == 1'b1, "R1 up_ready", int'(up_ready), 1);
        check(lo_req == 1'b0 && lo_clear == 1'b0, "R1 lo_req/lo_clear", int'({lo_req, lo_clear}), 0);
        check(st_valid == 1'b0, "R1 st_valid", int'(st_valid), 0);
    endtask

    task automatic t_success();
        delay_bound = TW'(100);
        push_one(16'h1234);
        step();
        check(lo_req == 1'b1, "R4 launch timing", int'(lo_req), 1);
        check(lo_data == 16'h1234, "R2 lo_data", int'(lo_data), 32'h1234);
        step();
        check(lo_req == 1'b0, "R4 single pulse", int'(lo_req), 0);
        lo_cfm = 1'b1;
        step();
        lo_cfm = 1'b0;
        check(st_valid && st_ok, "R5 success status", int'({st_valid, st_ok}), 3);
        check(lo_clear == 1'b0, "R5 no clear", int'(lo_clear), 0);
        step();
        check(st_valid == 1'b0, "R5 status one cycle", int'(st_valid), 0);
    endtask

    task automatic t_timeout(input int bound, input string tag);
        int early;
        early = 0;
        delay_bound = TW'(bound);
        push_one(16'h0BAD);
        for (int k = 1; k < bound; k++) begin
            step();
            if (lo_clear) early++;
        end
        check(early == 0, {tag, " clear too early"}, early, 0);
        step();
        check(lo_clear == 1'b1, {tag, " clear at deadline"}, int'(lo_clear), 1);
        for (int k = 0; k < 3; k++) begin
            step();
            check(lo_clear && !lo_req && !st_valid, "R7 clear held", int'({lo_clear, lo_req, st_valid}), 4);
        end
        lo_clr_ack = 1'b1;
        step();
        lo_clr_ack = 1'b0;
        check(st_valid && !st_ok, "R7 fail status after ack", int'({st_valid, st_ok}), 2);
        step();
    endtask

    task automatic t_tie();
        delay_bound = TW'(6);
        push_one(16'h00EE);
        for (int k = 1; k < 6; k++) step();
        lo_cfm = 1'b1;
        step();
        lo_cfm = 1'b0;
        check(st_valid && st_ok, "R8 tie is success", int'({st_valid, st_ok}), 3);
        check(lo_clear == 1'b0, "R8 no clear on tie", int'(lo_clear), 0);
        step();
        check(lo_clear == 1'b0, "R8 no clear after tie", int'(lo_clear), 0);
    endtask

    task automatic t_order_full();
        int r0, p0, guard;
        r0 = req_cnt;
        p0 = pass_cnt;
        delay_bound = TW'(120);
        for (int i = 0; i < 5; i++) begin
            up_valid = 1'b1;
            up_data  = DW'(16'hA0 + i);
            step();
        end
        check(up_ready == 1'b0, "R3 not ready when full", int'(up_ready), 0);
        up_valid = 1'b0;
        for (int i = 0; i < DP; i++) begin
            guard = 0;
            while (req_cnt == r0 + i && guard < 30) begin
                step();
                guard++;
            end
            step();
            lo_cfm = 1'b1;
            step();
            lo_cfm = 1'b0;
        end
        for (int k = 0; k < 20; k++) step();
        check(req_cnt - r0 == DP, "R3 fifth push dropped", req_cnt - r0, DP);
        check(pass_cnt - p0 == DP, "R5 all confirmed", pass_cnt - p0, DP);
        for (int i = 0; i < DP; i++)
            check(req_log[(r0 + i) % 16] == DW'(16'hA0 + i), "R2 launch order",
                  int'(req_log[(r0 + i) % 16]), 16'hA0 + i);
        check(up_ready == 1'b1, "R3 ready after drain", int'(up_ready), 1);
    endtask

    task automatic t_stale();
        int r0, f0, guard;
        r0 = req_cnt;
        f0 = fail_cnt;
        delay_bound = TW'(10);
        push_one(16'h0A0A);
        push_one(16'h0B0B);
        guard = 0;
        while (!lo_clear && guard < 40) begin
            step();
            guard++;
        end
        for (int k = 0; k < 3; k++) step();
        lo_clr_ack = 1'b1;
        step();
        lo_clr_ack = 1'b0;
        for (int k = 0; k < 10; k++) step();
        check(req_cnt - r0 == 1, "R9 stale entry not launched", req_cnt - r0, 1);
        check(fail_cnt - f0 == 2, "R9 stale entry failed", fail_cnt - f0, 2);
        check(lo_clear == 1'b0 && lo_req == 1'b0, "R9 queue quiet", int'({lo_clear, lo_req}), 0);
    endtask

    initial begin
        step();
        t_reset();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_success();
        t_timeout(5, "R6");
        t_tie();
        t_order_full();
        t_stale();
        // counter is TW=8 bits: repeated runs cross its wrap
        for (int i = 0; i < 8; i++) t_timeout(40, "R10");
        finish_run();
    end

endmodule